// File: doc/BRIEF.md
# Four-Bit Cascadable Arithmetic/Logic Slice

This block is a 4-bit arithmetic and logic slice with registered outputs. A four-bit select code together with a mode bit picks one of sixteen bitwise logic functions or one of sixteen arithmetic functions. The arithmetic functions include addition, subtraction, decrement and plain transfer of operand A. Every arithmetic function adds two derived operand words and the carry-in.

Subtraction adds the inverted subtrahend. With the carry-in clear this gives A minus B minus 1, and setting the carry-in turns it into the true difference. Because of this, the equality flag, which rises whenever all four result bits are one, marks equal operands in the subtract setting.

Wider words are built from several slices. Each slice exports a group generate bit and a group propagate bit so that an outside look-ahead stage can form the carry into the next slice.

Top module: `alu4_slice`

## Requirements
- R1: A clock edge with `rst` high clears `f_out`, `cout`, `grp_gen`, `grp_prop` and `eq_out` to 0.
- R2: Every output reflects the inputs sampled at the previous rising edge (one cycle of latency).
- R3: With `mode_logic`=0, `f_out` is the low 4 bits of OP1+OP2+`cin`. For each `fsel` value the operand pair (OP1, OP2) is: 0000 (A,0), 0001 (A|B,0), 0010 (A|~B,0), 0011 (1111,0), 0100 (A,A&~B), 0101 (A|B,A&~B), 0110 (A,~B), 0111 (A&~B,1111), 1000 (A,A&B), 1001 (A,B), 1010 (A|~B,A&B), 1011 (A&B,1111), 1100 (A,A), 1101 (A|B,A), 1110 (A|~B,A), 1111 (A,1111).
- R4: With `mode_logic`=1, `f_out` is bitwise. For each `fsel` value: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 0000, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 1111, 1101 A|~B, 1110 A|B, 1111 A.
- R5: In arithmetic mode, `cout` is bit 4 of OP1+OP2+`cin`.
- R6: In logic mode, `cout` is 0 and `cin` has no effect on `f_out`.
- R7: In both modes, `grp_gen` is the carry out of OP1+OP2 with no carry-in, and `grp_prop` is 1 exactly when (OP1|OP2)=1111. In arithmetic mode, `cout` equals `grp_gen` | (`grp_prop` & `cin`).
- R8: `eq_out` is 1 exactly when `f_out`=1111. As a result, A=B with `fsel`=0110, `mode_logic`=0 and `cin`=0 raises it.
- R9: With `fsel`=0110, `mode_logic`=0 and `cin`=1, `f_out` is (A−B) mod 16.
- R10: Two slices form an 8-bit unit when the upper slice's carry-in is `grp_gen` | (`grp_prop` & carry-in) of the lower slice. The upper slice's `f_out` and `cout` then equal bits 7..4 and bit 8 of the 8-bit R3 result, or of the R4 result in logic mode, where `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 4 | Operand A |
| b_in | input | 4 | Operand B |
| fsel | input | 4 | Function select code |
| mode_logic | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| cin | input | 1 | Active-high carry-in |
| f_out | output | 4 | Registered result |
| cout | output | 1 | Registered carry-out |
| grp_gen | output | 1 | Registered group generate |
| grp_prop | output | 1 | Registered group propagate |
| eq_out | output | 1 | Registered all-ones flag |

## Verification
The properties assume that every input is a known 0 or 1 on each rising edge and that `rst` is high on the first edge. The bench changes inputs only on falling edges and holds reset for the opening cycles.

The carry properties compare registered outputs with the carry-in of the previous cycle. They therefore depend on `cin` being driven for the whole run, and the bench drives it in every cycle. For the upper slice of the chain, the bench forms the carry-in from delayed copies of the lower slice's inputs, so that the two slices always see the same operation one cycle apart.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int FSEL_W = 4;

  // Select code split by the role each bit plays in forming the operand pair.
  typedef struct packed {
    logic y_ab;   // second operand takes A where B is 1
    logic y_anb;  // second operand takes A where B is 0
    logic x_nb;   // first operand ORs in ~B
    logic x_b;    // first operand ORs in B
  } fsel_t;
endpackage

// File: rtl/alu4_operand_xform.sv
module alu4_operand_xform
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fsel_t        sel,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop,
  output logic [W-1:0] half
);
  logic [W-1:0] opx;
  logic [W-1:0] opy;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      opx[i]  = a[i] | (b[i] & sel.x_b) | (~b[i] & sel.x_nb);
      opy[i]  = (a[i] & b[i] & sel.y_ab) | (a[i] & ~b[i] & sel.y_anb);
      gen[i]  = opx[i] & opy[i];
      prop[i] = opx[i] | opy[i];
      half[i] = opx[i] ^ opy[i];
    end
  end
endmodule

// File: rtl/alu4_lookahead.sv
module alu4_lookahead #(
  parameter int W = 4
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] prop,
  input  logic         cin,
  output logic [W-1:0] carry_in_bit,
  output logic         carry_out,
  output logic         grp_g,
  output logic         grp_p
);
  logic [W:0] cvec;

  // Every carry is a flat sum of products, so no carry waits on a lower one.
  always_comb begin
    logic term;
    logic acc;
    cvec[0] = cin;
    for (int i = 0; i < W; i++) begin
      acc = cin;
      for (int j = 0; j <= i; j++) acc = acc & prop[j];
      for (int k = 0; k <= i; k++) begin
        term = gen[k];
        for (int j = k + 1; j <= i; j++) term = term & prop[j];
        acc = acc | term;
      end
      cvec[i+1] = acc;
    end
  end

  always_comb begin
    logic term;
    grp_g = 1'b0;
    for (int k = 0; k < W; k++) begin
      term = gen[k];
      for (int j = k + 1; j < W; j++) term = term & prop[j];
      grp_g = grp_g | term;
    end
    grp_p = &prop;
  end

  assign carry_in_bit = cvec[W-1:0];
  assign carry_out    = cvec[W];
endmodule

// File: rtl/alu4_result.sv
module alu4_result #(
  parameter int W = 4
) (
  input  logic [W-1:0] half,
  input  logic [W-1:0] carry_in_bit,
  input  logic         logic_mode,
  output logic [W-1:0] f,
  output logic         all_ones
);
  always_comb begin
    if (logic_mode) f = ~half;
    else            f = half ^ carry_in_bit;
    all_ones = &f;
  end
endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      a_in,
  input  logic [W-1:0]      b_in,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              mode_logic,
  input  logic              cin,
  output logic [W-1:0]      f_out,
  output logic              cout,
  output logic              grp_gen,
  output logic              grp_prop,
  output logic              eq_out
);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  fsel_t        sel;
  logic [W-1:0] gen_w;
  logic [W-1:0] prop_w;
  logic [W-1:0] half_w;
  logic [W-1:0] cbit_w;
  logic [W-1:0] f_w;
  logic         co_w;
  logic         gg_w;
  logic         gp_w;
  logic         eq_w;

  assign sel = fsel_t'(fsel);

  alu4_operand_xform #(.W(W)) u_xform (
    .a(a_in), .b(b_in), .sel(sel),
    .gen(gen_w), .prop(prop_w), .half(half_w)
  );

  alu4_lookahead #(.W(W)) u_cla (
    .gen(gen_w), .prop(prop_w), .cin(cin),
    .carry_in_bit(cbit_w), .carry_out(co_w),
    .grp_g(gg_w), .grp_p(gp_w)
  );

  alu4_result #(.W(W)) u_res (
    .half(half_w), .carry_in_bit(cbit_w), .logic_mode(mode_logic),
    .f(f_w), .all_ones(eq_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      f_out    <= '0;
      cout     <= 1'b0;
      grp_gen  <= 1'b0;
      grp_prop <= 1'b0;
      eq_out   <= 1'b0;
    end else begin
      f_out    <= f_w;
      cout     <= co_w & ~mode_logic;
      grp_gen  <= gg_w;
      grp_prop <= gp_w;
      eq_out   <= eq_w;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (f_out == '0 && !cout && !grp_gen && !grp_prop && !eq_out));

  // R8
  eq_match_chk: assert property (@(posedge clk) disable iff (rst)
    eq_out == (f_out == ONES));

  // R6
  logic_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    mode_logic |=> !cout);

  // R7
  cascade_carry_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_logic |=> (cout == (grp_gen | (grp_prop & $past(cin)))));

  // R3
  transfer_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_logic && fsel == 4'b0000 && !cin) |=> (f_out == $past(a_in)));
endmodule

// File: tb/test_alu4_slice.sv
module test_alu4_slice;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a8 = '0;
  logic [7:0] b8 = '0;
  logic [3:0] fsel = '0;
  logic       mode = 1'b0;
  logic       cin = 1'b0;
  logic       drv_valid = 1'b0;

  logic [3:0] lo_f, hi_f;
  logic       lo_co, lo_gg, lo_gp, lo_eq;
  logic       hi_co, hi_gg, hi_gp, hi_eq;

  logic [3:0] a_hi_d, b_hi_d, fsel_d;
  logic       mode_d, cin_d, v1, v2;
  logic       hi_cin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [3:0] f;
    logic co, gg, gp, eq;
    logic m;
    logic sub;
  } lo_exp_t;
  typedef struct {
    logic [3:0] f;
    logic co;
    logic m;
  } hi_exp_t;

  lo_exp_t q_lo[$];
  hi_exp_t q_hi[$];

  always #5 clk = ~clk;

  alu4_slice i_alu4_slice (
    .clk(clk), .rst(rst), .a_in(a8[3:0]), .b_in(b8[3:0]), .fsel(fsel),
    .mode_logic(mode), .cin(cin), .f_out(lo_f), .cout(lo_co),
    .grp_gen(lo_gg), .grp_prop(lo_gp), .eq_out(lo_eq)
  );

  // Outside look-ahead stage: carry into the upper slice (R10).
  assign hi_cin = lo_gg | (lo_gp & cin_d);

  alu4_slice i_alu4_slice_hi (
    .clk(clk), .rst(rst), .a_in(a_hi_d), .b_in(b_hi_d), .fsel(fsel_d),
    .mode_logic(mode_d), .cin(hi_cin), .f_out(hi_f), .cout(hi_co),
    .grp_gen(hi_gg), .grp_prop(hi_gp), .eq_out(hi_eq)
  );

  always_ff @(posedge clk) begin
    a_hi_d <= a8[7:4];
    b_hi_d <= b8[7:4];
    fsel_d <= fsel;
    mode_d <= mode;
    cin_d  <= cin;
    v1     <= rst ? 1'b0 : drv_valid;
    v2     <= rst ? 1'b0 : v1;
  end

  // Operand pairs of R3, applied bitwise to a word of any width up to 8.
  function automatic void op_pair(input logic [3:0] s, input logic [7:0] a, b,
                                  output logic [7:0] o1, output logic [7:0] o2);
    case (s)
      4'b0000: begin o1 = a;        o2 = 8'h00;  end
      4'b0001: begin o1 = a | b;    o2 = 8'h00;  end
      4'b0010: begin o1 = a | ~b;   o2 = 8'h00;  end
      4'b0011: begin o1 = 8'hFF;    o2 = 8'h00;  end
      4'b0100: begin o1 = a;        o2 = a & ~b; end
      4'b0101: begin o1 = a | b;    o2 = a & ~b; end
      4'b0110: begin o1 = a;        o2 = ~b;     end
      4'b0111: begin o1 = a & ~b;   o2 = 8'hFF;  end
      4'b1000: begin o1 = a;        o2 = a & b;  end
      4'b1001: begin o1 = a;        o2 = b;      end
      4'b1010: begin o1 = a | ~b;   o2 = a & b;  end
      4'b1011: begin o1 = a & b;    o2 = 8'hFF;  end
      4'b1100: begin o1 = a;        o2 = a;      end
      4'b1101: begin o1 = a | b;    o2 = a;      end
      4'b1110: begin o1 = a | ~b;   o2 = a;      end
      default: begin o1 = a;        o2 = 8'hFF;  end
    endcase
  endfunction

  // Bitwise functions of R4.
  function automatic logic [7:0] logic_fn(input logic [3:0] s, input logic [7:0] a, b);
    case (s)
      4'b0000: return ~a;
      4'b0001: return ~(a | b);
      4'b0010: return ~a & b;
      4'b0011: return 8'h00;
      4'b0100: return ~(a & b);
      4'b0101: return ~b;
      4'b0110: return a ^ b;
      4'b0111: return a & ~b;
      4'b1000: return ~a | b;
      4'b1001: return ~(a ^ b);
      4'b1010: return b;
      4'b1011: return a & b;
      4'b1100: return 8'hFF;
      4'b1101: return a | ~b;
      4'b1110: return a | b;
      default: return a;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic [3:0] s, input logic [7:0] a,
                       input logic [7:0] b, input logic c);
    logic [7:0] o1, o2, o1l, o2l;
    logic [8:0] sum8;
    logic [4:0] sum4, gsum4;
    lo_exp_t el;
    hi_exp_t eh;
    a8 = a; b8 = b; fsel = s; mode = m; cin = c; drv_valid = 1'b1;
    op_pair(s, a, b, o1, o2);
    op_pair(s, {4'h0, a[3:0]}, {4'h0, b[3:0]}, o1l, o2l);
    sum4  = {1'b0, o1l[3:0]} + {1'b0, o2l[3:0]} + {4'b0, c};
    gsum4 = {1'b0, o1l[3:0]} + {1'b0, o2l[3:0]};
    sum8  = {1'b0, o1} + {1'b0, o2} + {8'b0, c};
    el.m   = m;
    el.sub = (!m && s == 4'b0110 && c);
    el.f   = m ? logic_fn(s, a, b) & 8'h0F : sum4[3:0];
    el.co  = m ? 1'b0 : sum4[4];
    el.gg  = gsum4[4];
    el.gp  = ((o1l[3:0] | o2l[3:0]) == 4'hF);
    el.eq  = (el.f == 4'hF);
    eh.m   = m;
    eh.f   = m ? logic_fn(s, a, b) >> 4 : sum8[7:4];
    eh.co  = m ? 1'b0 : sum8[8];
    q_lo.push_back(el);
    q_hi.push_back(eh);
    @(negedge clk);
  endtask

  // Monitor. R2: an item driven at one falling edge is compared at the next,
  // after the single output register; the upper slice adds one more stage.
  always @(negedge clk) begin
    if (v1 && q_lo.size() > 0) begin
      lo_exp_t e;
      e = q_lo.pop_front();
      if (e.sub) chk("R9 R2 f", {4'h0, lo_f}, {4'h0, e.f});
      else if (e.m) chk("R4 R6 f", {4'h0, lo_f}, {4'h0, e.f});
      else chk("R3 R2 f", {4'h0, lo_f}, {4'h0, e.f});
      chk(e.m ? "R6 cout" : "R5 cout", {7'h0, lo_co}, {7'h0, e.co});
      chk("R7 grp_gen", {7'h0, lo_gg}, {7'h0, e.gg});
      chk("R7 grp_prop", {7'h0, lo_gp}, {7'h0, e.gp});
      chk("R8 eq", {7'h0, lo_eq}, {7'h0, e.eq});
    end
    if (v2 && q_hi.size() > 0) begin
      hi_exp_t h;
      h = q_hi.pop_front();
      chk("R10 upper f", {4'h0, hi_f}, {4'h0, h.f});
      chk("R10 upper cout", {7'h0, hi_co}, {7'h0, h.co});
    end
  end

  task automatic chk_reset_state();
    // R1
    chk("R1 f", {4'h0, lo_f}, 8'h00);
    chk("R1 cout", {7'h0, lo_co}, 8'h00);
    chk("R1 grp_gen", {7'h0, lo_gg}, 8'h00);
    chk("R1 grp_prop", {7'h0, lo_gp}, 8'h00);
    chk("R1 eq", {7'h0, lo_eq}, 8'h00);
    chk("R1 upper f", {4'h0, hi_f}, 8'h00);
    chk("R1 upper eq", {7'h0, hi_eq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state();
    rst = 1'b0;
    @(negedge clk);
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            for (int c = 0; c < 2; c++)
              drive(m[0], s[3:0], {b[3:0], a[3:0]}, {a[3:0], b[3:0]}, c[0]);
    drv_valid = 1'b0;
    repeat (4) @(negedge clk);
    // Reset in mid-run with nonzero inputs held (R1).
    a8 = 8'hFF; b8 = 8'hFF; fsel = 4'b1100; mode = 1'b1; cin = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk_reset_state();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule